// File: doc/BRIEF.md
# Burst-Mode Conversion Sequencer for a Successive-Approximation ADC

This block controls an external successive-approximation converter and sums its results. It runs on a fast sequencer clock of its own, so a full group of conversions can finish inside one period of a slow system clock. A convert-start request from the system side wakes the converter. If the converter is powered down, the block first applies power and waits a programmable number of cycles. It then runs a chosen number of track-then-convert cycles and adds each result to an accumulator.

The block publishes the total only when the whole group is complete. At that point it evaluates a window compare against a low and a high threshold and raises an interrupt flag in the system clock domain.

In burst mode, one request runs the whole group back to back. Afterwards the converter is either powered down or left powered, as a configuration bit selects. In single mode, each request runs one conversion, and the flag waits for the last conversion of the group.

Top module: `burst_adc_seq`

## Requirements
- R1: The 3-bit `rptSel` field picks the group size. Codes 0..5 give 1, 4, 8, 16, 32 and 64 conversions. Codes 6 and 7 give 1 conversion.
- R2: With `burstEn`=1, a single start request runs exactly the group size of conversions back to back, with no further request needed.
- R3: With `burstEn`=0, each start request runs exactly one conversion, then the block waits with track and convert low for the next request.
- R4: `irqFlag` (system domain) stays low until the last conversion of a group has been summed, then rises. A start request clears it.
- R5: `accSum` equals the exact sum of the group's samples. The accumulator is cleared at the start of each group, and its width `SAMPLE_W`+6 holds 64 full-scale samples without overflow.
- R6: `winHit` is 1 when the completed sum is at or below `loThr`, or at or above `hiThr`. `winHit` and `accSum` change only when a group completes, never on a partial sum.
- R7: After a burst-mode group, `adcPwr` equals `idleOn`. In single mode the converter stays powered between conversions and after the group.
- R8: A start request from the powered-down state raises `adcPwr` and holds `adcTrack` low for `pwrUpCycles`+1 sequencer cycles before tracking. From the powered idle state, tracking begins with no power-up phase.
- R9: Each conversion is preceded by `trackCycles`+1 cycles of `adcTrack`, plus 3 more cycles when `extraTrack`=1.
- R10: A start request that arrives while a group is running is ignored and does not add conversions.
- R11: `adcConv` is held until `adcValid`. `adcTrack` and `adcConv` are never high together, and neither is high while `adcPwr` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sysClk | input | 1 | Slow system clock |
| seqClk | input | 1 | Fast sequencer clock |
| rstN | input | 1 | Asynchronous active-low reset, both domains |
| startIn | input | 1 | Convert-start request, system domain, at least 4 system cycles apart |
| burstEn | input | 1 | 1: one request runs the whole group; 0: one conversion per request |
| idleOn | input | 1 | Burst mode: keep converter powered after a group |
| extraTrack | input | 1 | Add 3 tracking cycles before each conversion |
| rptSel | input | 3 | Group-size code |
| pwrUpCycles | input | PWR_W | Power-up wait, counted as value+1 cycles |
| trackCycles | input | TRK_W | Tracking time, counted as value+1 cycles |
| loThr | input | SAMPLE_W+6 | Window low threshold |
| hiThr | input | SAMPLE_W+6 | Window high threshold |
| adcData | input | SAMPLE_W | Converter result |
| adcValid | input | 1 | Converter result valid, ends a conversion |
| adcPwr | output | 1 | Converter power enable |
| adcTrack | output | 1 | Converter track phase |
| adcConv | output | 1 | Converter convert phase |
| accSum | output | SAMPLE_W+6 | Sum of the last completed group |
| winHit | output | 1 | Window compare result of the last completed group |
| irqFlag | output | 1 | End-of-group flag, system domain |

## Verification
A wrong conversion counter shows at the ports within one group, as a wrong number of valid handshakes and a wrong `accSum` when `irqFlag` rises. A wrong phase timer shows on the very next conversion, as a track run of the wrong length or a wrong power-up gap. A stale accumulator or an early publish shows as a sum that differs from the arithmetic total, or as `irqFlag` rising before the last sample in single mode. All of these are visible within a few system cycles of the group's end.

// File: rtl/burst_adc_pkg.sv
package burst_adc_pkg;

  localparam int CNT_W = 7;
  localparam int XTRA_CYCLES = 3;

  typedef enum logic [2:0] {
    SeqOff,
    SeqIdle,
    SeqPwrUp,
    SeqTrack,
    SeqXTrack,
    SeqConv
  } seqState_e;

  // control-to-datapath strobes
  typedef struct packed {
    logic clr;   // start of a new accumulation
    logic add;   // accept one sample
    logic last;  // accepted sample completes the group
  } accStrobe_t;

  function automatic logic [CNT_W-1:0] rptCount(input logic [2:0] sel);
    case (sel)
      3'd1:    rptCount = CNT_W'(4);
      3'd2:    rptCount = CNT_W'(8);
      3'd3:    rptCount = CNT_W'(16);
      3'd4:    rptCount = CNT_W'(32);
      3'd5:    rptCount = CNT_W'(64);
      default: rptCount = CNT_W'(1);
    endcase
  endfunction

endpackage

// File: rtl/burst_adc_ctrl.sv
module burst_adc_ctrl
  import burst_adc_pkg::*;
#(
  parameter int PWR_W = 4,
  parameter int TRK_W = 4
) (
  input  logic             seqClk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic             burstEn,
  input  logic             idleOn,
  input  logic             extraTrack,
  input  logic [2:0]       rptSel,
  input  logic [PWR_W-1:0] pwrUpCycles,
  input  logic [TRK_W-1:0] trackCycles,
  input  logic             adcValid,
  output logic             adcPwr,
  output logic             adcTrack,
  output logic             adcConv,
  output accStrobe_t       strobe,
  output logic             doneTgl
);

  localparam int TIM_W = (PWR_W > TRK_W) ? PWR_W : TRK_W;

  seqState_e        state, stateNext;
  logic [TIM_W-1:0] tmr, tmrNext;
  logic [CNT_W-1:0] convCnt, convNext, totalN;

  assign totalN = rptCount(rptSel);

  always_comb begin
    stateNext = state;
    tmrNext   = tmr;
    convNext  = convCnt;
    strobe    = '0;
    case (state)
      SeqOff: begin
        if (startPulse) begin
          strobe.clr = (convCnt == '0);
          stateNext  = SeqPwrUp;
          tmrNext    = TIM_W'(pwrUpCycles);
        end
      end
      SeqIdle: begin
        if (startPulse) begin
          strobe.clr = (convCnt == '0);
          stateNext  = SeqTrack;
          tmrNext    = TIM_W'(trackCycles);
        end
      end
      SeqPwrUp: begin
        if (tmr == '0) begin
          stateNext = SeqTrack;
          tmrNext   = TIM_W'(trackCycles);
        end else begin
          tmrNext = tmr - 1'b1;
        end
      end
      SeqTrack: begin
        if (tmr == '0) begin
          stateNext = extraTrack ? SeqXTrack : SeqConv;
          tmrNext   = TIM_W'(XTRA_CYCLES - 1);
        end else begin
          tmrNext = tmr - 1'b1;
        end
      end
      SeqXTrack: begin
        if (tmr == '0) stateNext = SeqConv;
        else           tmrNext   = tmr - 1'b1;
      end
      SeqConv: begin
        if (adcValid) begin
          strobe.add = 1'b1;
          if (convCnt >= totalN - 1'b1) begin
            strobe.last = 1'b1;
            convNext    = '0;
            stateNext   = (burstEn && !idleOn) ? SeqOff : SeqIdle;
          end else begin
            convNext  = convCnt + 1'b1;
            stateNext = burstEn ? SeqTrack : SeqIdle;
            tmrNext   = TIM_W'(trackCycles);
          end
        end
      end
      default: stateNext = SeqOff;
    endcase
  end

  always_ff @(posedge seqClk or negedge rstN) begin
    if (!rstN) begin
      state   <= SeqOff;
      tmr     <= '0;
      convCnt <= '0;
      doneTgl <= 1'b0;
    end else begin
      state   <= stateNext;
      tmr     <= tmrNext;
      convCnt <= convNext;
      if (strobe.last) doneTgl <= ~doneTgl;
    end
  end

  assign adcPwr   = (state != SeqOff);
  assign adcTrack = (state == SeqTrack) || (state == SeqXTrack);
  assign adcConv  = (state == SeqConv);

  a_r11_phase_excl: assert property (@(posedge seqClk) disable iff (!rstN)
    !(adcTrack && adcConv));
  a_r11_power_first: assert property (@(posedge seqClk) disable iff (!rstN)
    (adcTrack || adcConv) |-> adcPwr);
  a_r8_wake_no_track: assert property (@(posedge seqClk) disable iff (!rstN)
    $rose(adcPwr) |-> !adcTrack);
  a_r10_busy_ignore: assert property (@(posedge seqClk) disable iff (!rstN)
    (adcConv && startPulse && !adcValid) |=> adcConv);
  a_r2_count_bound: assert property (@(posedge seqClk) disable iff (!rstN)
    convCnt < totalN);

endmodule

// File: rtl/burst_adc_dp.sv
module burst_adc_dp
  import burst_adc_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int ACC_W    = SAMPLE_W + 6
) (
  input  logic                seqClk,
  input  logic                rstN,
  input  accStrobe_t          strobe,
  input  logic [SAMPLE_W-1:0] adcData,
  input  logic [ACC_W-1:0]    loThr,
  input  logic [ACC_W-1:0]    hiThr,
  output logic [ACC_W-1:0]    accSum,
  output logic                winHit
);

  logic [ACC_W-1:0] runAcc;
  logic [ACC_W:0]   wideSum;
  logic [ACC_W-1:0] nextSum;

  assign wideSum = {1'b0, runAcc} + (ACC_W+1)'(adcData);
  assign nextSum = wideSum[ACC_W-1:0];

  always_ff @(posedge seqClk or negedge rstN) begin
    if (!rstN) begin
      runAcc <= '0;
      accSum <= '0;
      winHit <= 1'b0;
    end else begin
      if (strobe.clr)      runAcc <= '0;
      else if (strobe.add) runAcc <= nextSum;
      if (strobe.add && strobe.last) begin
        accSum <= nextSum;
        winHit <= (nextSum <= loThr) || (nextSum >= hiThr);
      end
    end
  end

  a_r5_no_overflow: assert property (@(posedge seqClk) disable iff (!rstN)
    strobe.add |-> !wideSum[ACC_W]);
  a_r6_publish_at_end: assert property (@(posedge seqClk) disable iff (!rstN)
    !$stable(accSum) |-> $past(strobe.last));
  a_r6_window_at_end: assert property (@(posedge seqClk) disable iff (!rstN)
    !$stable(winHit) |-> $past(strobe.last));

endmodule

// File: rtl/burst_adc_seq.sv
module burst_adc_seq
  import burst_adc_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int PWR_W    = 4,
  parameter int TRK_W    = 4,
  localparam int ACC_W   = SAMPLE_W + 6
) (
  input  logic                sysClk,
  input  logic                seqClk,
  input  logic                rstN,
  input  logic                startIn,
  input  logic                burstEn,
  input  logic                idleOn,
  input  logic                extraTrack,
  input  logic [2:0]          rptSel,
  input  logic [PWR_W-1:0]    pwrUpCycles,
  input  logic [TRK_W-1:0]    trackCycles,
  input  logic [ACC_W-1:0]    loThr,
  input  logic [ACC_W-1:0]    hiThr,
  input  logic [SAMPLE_W-1:0] adcData,
  input  logic                adcValid,
  output logic                adcPwr,
  output logic                adcTrack,
  output logic                adcConv,
  output logic [ACC_W-1:0]    accSum,
  output logic                winHit,
  output logic                irqFlag
);

  logic [2:0] startSync;
  logic       startPulse;
  logic [2:0] doneSync;
  logic       doneTgl;
  accStrobe_t strobe;

  // system -> sequencer: two-flop synchroniser plus rising-edge detect
  always_ff @(posedge seqClk or negedge rstN) begin
    if (!rstN) startSync <= '0;
    else       startSync <= {startSync[1:0], startIn};
  end
  assign startPulse = startSync[1] & ~startSync[2];

  // sequencer -> system: toggle handshake sets the sticky flag
  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) begin
      doneSync <= '0;
      irqFlag  <= 1'b0;
    end else begin
      doneSync <= {doneSync[1:0], doneTgl};
      if (doneSync[2] != doneSync[1]) irqFlag <= 1'b1;
      else if (startIn)               irqFlag <= 1'b0;
    end
  end

  burst_adc_ctrl #(.PWR_W(PWR_W), .TRK_W(TRK_W)) uCtrl (
    .seqClk      (seqClk),
    .rstN        (rstN),
    .startPulse  (startPulse),
    .burstEn     (burstEn),
    .idleOn      (idleOn),
    .extraTrack  (extraTrack),
    .rptSel      (rptSel),
    .pwrUpCycles (pwrUpCycles),
    .trackCycles (trackCycles),
    .adcValid    (adcValid),
    .adcPwr      (adcPwr),
    .adcTrack    (adcTrack),
    .adcConv     (adcConv),
    .strobe      (strobe),
    .doneTgl     (doneTgl)
  );

  burst_adc_dp #(.SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W)) uDp (
    .seqClk  (seqClk),
    .rstN    (rstN),
    .strobe  (strobe),
    .adcData (adcData),
    .loThr   (loThr),
    .hiThr   (hiThr),
    .accSum  (accSum),
    .winHit  (winHit)
  );

  a_r4_flag_from_done: assert property (@(posedge sysClk) disable iff (!rstN)
    $rose(irqFlag) |-> ($past(doneSync[2]) != $past(doneSync[1])));

endmodule

// File: tb/burst_adc_seq_test.sv
module burst_adc_seq_test;

  localparam int SW = 10;
  localparam int AW = SW + 6;

  logic sysClk = 0, seqClk = 0, rstN = 0;
  logic startIn = 0, burstEn = 0, idleOn = 0, extraTrack = 0;
  logic [2:0] rptSel = 0;
  logic [3:0] pwrUpCycles = 0, trackCycles = 0;
  logic [AW-1:0] loThr = 0, hiThr = 0;
  logic [SW-1:0] adcData = 0;
  logic adcValid = 0;
  logic adcPwr, adcTrack, adcConv, winHit, irqFlag;
  logic [AW-1:0] accSum;

  burst_adc_seq uut (
    .sysClk(sysClk), .seqClk(seqClk), .rstN(rstN), .startIn(startIn),
    .burstEn(burstEn), .idleOn(idleOn), .extraTrack(extraTrack),
    .rptSel(rptSel), .pwrUpCycles(pwrUpCycles), .trackCycles(trackCycles),
    .loThr(loThr), .hiThr(hiThr), .adcData(adcData), .adcValid(adcValid),
    .adcPwr(adcPwr), .adcTrack(adcTrack), .adcConv(adcConv),
    .accSum(accSum), .winHit(winHit), .irqFlag(irqFlag)
  );

  always #2.5 seqClk = ~seqClk;   // 200 MHz sequencer clock
  always #20  sysClk = ~sysClk;   // slow system clock

  int vecs = 0, errs = 0;
  int expTrack = 1;
  int convCount = 0;
  int sampleIdx = 0;
  int expSum = 0;
  bit maxData = 0;
  int pwrLen = 0, pwrRises = 0;
  bit pwrMeasure = 0;
  bit finished = 0;

  function automatic int sampleVal(int k, bit full);
    return full ? 1023 : ((k * 97 + 13) % 1024);
  endfunction

  function automatic int groupSize(int sel);
    case (sel)
      1: return 4; 2: return 8; 3: return 16; 4: return 32; 5: return 64;
      default: return 1;
    endcase
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // converter model and phase monitors, on the falling sequencer edge
  initial begin
    int conCnt = 0, trkRun = 0;
    bit prevPwr = 0;
    forever begin
      @(negedge seqClk);
      if (adcConv && !adcValid) begin
        conCnt++;
        if (conCnt == 2) begin
          adcValid = 1;
          adcData = SW'(sampleVal(sampleIdx, maxData));
          expSum += sampleVal(sampleIdx, maxData);
          sampleIdx++;
          convCount++;
        end
      end else begin
        adcValid = 0;
        conCnt = 0;
      end
      if (adcTrack) trkRun++;
      else if (trkRun > 0) begin
        check(trkRun == expTrack, "R9 track length", trkRun, expTrack);
        trkRun = 0;
      end
      if (adcPwr && !prevPwr) begin
        pwrMeasure = 1; pwrLen = 0; pwrRises++;
      end
      if (pwrMeasure) begin
        if (adcTrack) pwrMeasure = 0;
        else pwrLen++;
      end
      prevPwr = adcPwr;
    end
  end

  task automatic pulseStart(bit chkClr);
    @(negedge sysClk) startIn = 1;
    @(negedge sysClk) startIn = 0;
    if (chkClr) check(irqFlag == 0, "R4 flag cleared by start", irqFlag, 0);
    repeat (4) @(negedge sysClk);
  endtask

  task automatic waitIrq(output bit got);
    got = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge sysClk);
      if (irqFlag) begin got = 1; break; end
    end
  endtask

  task automatic runBurst(int sel, bit idle, bit xtra, int pw, int trk, int winCase);
    bit got, wasOff;
    int n, rises0, pred, expWin;
    @(negedge sysClk);
    burstEn = 1; idleOn = idle; extraTrack = xtra; rptSel = 3'(sel);
    pwrUpCycles = 4'(pw); trackCycles = 4'(trk);
    expTrack = trk + 1 + (xtra ? 3 : 0);
    n = groupSize(sel);
    pred = 0;
    for (int i = 0; i < n; i++) pred += sampleVal(sampleIdx + i, maxData);
    case (winCase % 4)
      0: begin loThr = AW'(pred > 0 ? pred - 1 : 0); hiThr = AW'(pred + 1); end
      1: begin loThr = AW'(pred); hiThr = '1; end
      2: begin loThr = '0; hiThr = AW'(pred); end
      default: begin loThr = AW'(pred / 2); hiThr = AW'(pred * 2 + 1); end
    endcase
    expSum = 0; convCount = 0;
    wasOff = !adcPwr; rises0 = pwrRises;
    pulseStart(1);
    waitIrq(got);
    repeat (2) @(negedge sysClk);
    check(got, "R4 flag after group", irqFlag, 1);
    check(convCount == n, "R1 R2 conversions per start", convCount, n);
    check(int'(accSum) == expSum, "R5 sum", int'(accSum), expSum);
    expWin = ((expSum <= int'(loThr)) || (expSum >= int'(hiThr))) ? 1 : 0;
    check(int'(winHit) == expWin, "R6 window", winHit, expWin);
    check(adcPwr == idle, "R7 idle power", adcPwr, idle);
    if (wasOff) check(pwrLen == pw + 1, "R8 power-up wait", pwrLen, pw + 1);
    else check(pwrRises == rises0, "R8 no power-up from idle", pwrRises - rises0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge seqClk);
    if (!finished) begin
      errs++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    bit got;
    repeat (3) @(negedge sysClk);
    check(adcPwr == 0 && adcTrack == 0 && adcConv == 0, "R11 reset phases", adcPwr, 0);
    check(irqFlag == 0 && accSum == 0 && winHit == 0, "R4 reset flag", irqFlag, 0);
    rstN = 1;
    repeat (2) @(negedge sysClk);

    // burst-mode sweep: every code, idle mode, extra tracking
    for (int s = 0; s < 8; s++)
      for (int m = 0; m < 4; m++)
        runBurst(s, m[0], m[1], (s + m) % 4, (s * 3 + m) % 3, s + m);

    // R5: 64 full-scale samples without overflow
    maxData = 1;
    runBurst(5, 1, 0, 1, 0, 2);
    check(int'(accSum) == 64 * 1023, "R5 full scale", int'(accSum), 64 * 1023);
    maxData = 0;

    // R3: single mode, one conversion per request, flag after the fourth
    @(negedge sysClk);
    burstEn = 0; idleOn = 0; extraTrack = 1; rptSel = 3'd1;
    pwrUpCycles = 4'd2; trackCycles = 4'd1; expTrack = 5;
    loThr = '0; hiThr = '1;
    expSum = 0; convCount = 0;
    for (int k = 0; k < 4; k++) begin
      pulseStart(k == 0);
      for (int i = 0; i < 200 && convCount < k + 1; i++) @(negedge sysClk);
      repeat (3) @(negedge sysClk);
      check(convCount == k + 1, "R3 one conversion per start", convCount, k + 1);
      check(adcTrack == 0 && adcConv == 0, "R3 waits for request", adcTrack, 0);
      check(adcPwr == 1, "R7 single mode stays powered", adcPwr, 1);
      if (k < 3) check(irqFlag == 0, "R3 R4 no flag on partial group", irqFlag, 0);
    end
    waitIrq(got);
    repeat (2) @(negedge sysClk);
    check(got, "R3 flag after fourth", irqFlag, 1);
    check(int'(accSum) == expSum, "R3 R5 single-mode sum", int'(accSum), expSum);

    // R10: a request during a running burst is ignored
    @(negedge sysClk);
    burstEn = 1; idleOn = 0; extraTrack = 0; rptSel = 3'd4;
    trackCycles = 4'd1; expTrack = 2;
    expSum = 0; convCount = 0;
    pulseStart(1);
    for (int i = 0; i < 200 && convCount < 3; i++) @(negedge sysClk);
    check(adcPwr == 1, "R10 burst still running", adcPwr, 1);
    pulseStart(0);
    waitIrq(got);
    repeat (30) @(negedge sysClk);
    check(got, "R10 flag", irqFlag, 1);
    check(convCount == 32, "R10 extra request ignored", convCount, 32);
    check(adcPwr == 0 && adcTrack == 0, "R10 no second burst", adcTrack, 0);
    check(int'(accSum) == expSum, "R10 sum", int'(accSum), expSum);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule